// File: doc/BRIEF.md
# Scatter Region Descriptor Builder

The builder takes a list of memory buffer fragments and turns it into the descriptor table that a bus-master disk DMA engine walks. Each fragment arrives on a valid/ready stream as a 32-bit start address, a byte length and a marker on the final fragment of the list. When a fragment starts exactly where the region built so far ends, it is added to that region. Otherwise the open region is closed and a new one begins.

Each closed region is cut into descriptors that never cross a 64 KB address boundary. The builder produces one descriptor per clock cycle and writes the descriptors to a small on-chip table through a write port. The last descriptor of the list carries an end-of-table flag. While a region is being cut, the builder does not accept fragments.

The build ends in one of three ways: done, with an entry count; a table-overflow error; or an empty-list error. On either error the caller can fall back to programmed I/O for that request. Buffers are assumed to be 16-bit aligned.

Top module: `sg_region_builder`

## Requirements
- R1: Each table word is 64 bits. Bits 31:0 hold the descriptor's start address. Bits 47:32 hold its byte count. Bit 63 is the end-of-table flag. Bits 62:48 are zero.
- R2: A nonzero fragment whose address equals the open region's start plus its accumulated length extends that region, so no extra descriptor is produced at the joint. Any other nonzero fragment closes the open region and starts a new one.
- R3: No descriptor crosses a 64 KB boundary. A descriptor's length is the smaller of two values: the bytes left in the region, and 0x10000 minus the low 16 address bits. The next descriptor starts where the previous one ended.
- R4: The byte count field holds the length modulo 65536, so a full 64 KB descriptor carries a count of 0.
- R5: Only the final descriptor of a build has bit 63 set. It is written in the same cycle that build_done rises.
- R6: The descriptors of a build are written at table indices 0, 1, 2, … in address order, one write per descriptor. At done, entry_count equals the number of descriptors.
- R7: A build that needs more than DEPTH descriptors raises err_overflow, and build_done stays low. Fragments still to come in that list are accepted and dropped up to the one marked last. The error is reported only then, or at once if the last fragment was already taken.
- R8: A list with no bytes at all raises err_empty with entry_count 0, and no table write is made.
- R9: A zero-length fragment adds no descriptor and does not break the merging of the fragments on either side of it.
- R10: frag_ready is low from the cycle after a fragment closes a region until that region has been fully cut. The first fragment accepted after done or an error starts a new build and clears build_done, the error flags and entry_count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frag_valid | input | 1 | Fragment offered |
| frag_ready | output | 1 | Builder takes the fragment this cycle |
| frag_addr | input | 32 | Fragment start address |
| frag_len | input | FLEN_W | Fragment length in bytes |
| frag_last | input | 1 | Final fragment of the list |
| tbl_we | output | 1 | Table write strobe |
| tbl_idx | output | IDX_W | Table entry index |
| tbl_data | output | 64 | Descriptor word |
| build_done | output | 1 | Table complete (held until next build) |
| err_overflow | output | 1 | Table capacity exceeded |
| err_empty | output | 1 | List held no bytes |
| entry_count | output | CNT_W | Descriptors produced |

## Verification
A fault in the merge compare or in the region register shows up as a wrong entry_count, or as a descriptor with a wrong address, once the list completes. A fault in the split arithmetic shows up in the table word written in the same cycle: its address plus length crosses 64 KB, or the following start address is wrong. A descriptor held back or written late shows up as a gap in the table indices, or as the end flag on the wrong entry, at the cycle build_done rises. A wrong entry counter shows up as a missed or premature overflow at the DEPTH boundary.

// File: rtl/sgb_pkg.sv
package sgb_pkg;
    typedef enum logic [1:0] {
        ST_ACCEPT = 2'd0,
        ST_SPLIT  = 2'd1,
        ST_FLUSH  = 2'd2,
        ST_DRAIN  = 2'd3
    } bld_st_e;

    localparam int ADDR_W   = 32;
    localparam int WORD_W   = 64;
    localparam int CNT_FLD  = 16;
    localparam int EOT_BIT  = 63;
    localparam int SPAN_W   = CNT_FLD + 1;

    function automatic logic [WORD_W-1:0] pack_desc(input logic [ADDR_W-1:0] a,
                                                    input logic [CNT_FLD-1:0] c,
                                                    input logic eot);
        return {eot, 15'b0, c, a};
    endfunction
endpackage

// File: rtl/sgb_chunker.sv
module sgb_chunker
    import sgb_pkg::*;
#(
    parameter int RLEN_W = 24
) (
    input  logic [ADDR_W-1:0]  cur_addr,
    input  logic [RLEN_W-1:0]  cur_rem,
    output logic [SPAN_W-1:0]  chunk_len,
    output logic               last_chunk
);
    logic [SPAN_W-1:0] room;

    always_comb begin
        room = SPAN_W'(17'h10000) - {1'b0, cur_addr[CNT_FLD-1:0]};
        if (cur_rem < RLEN_W'(room)) begin
            chunk_len = SPAN_W'(cur_rem);
        end else begin
            chunk_len = room;
        end
        last_chunk = (cur_rem == RLEN_W'(chunk_len));
    end
endmodule

// File: rtl/sgb_merge.sv
module sgb_merge
    import sgb_pkg::*;
#(
    parameter int RLEN_W = 24
) (
    input  logic               rgn_vld,
    input  logic [ADDR_W-1:0]  rgn_base,
    input  logic [RLEN_W-1:0]  rgn_len,
    input  logic [ADDR_W-1:0]  frag_addr,
    output logic               contig
);
    logic [ADDR_W-1:0] rgn_end;

    always_comb begin
        rgn_end = rgn_base + ADDR_W'(rgn_len);
        contig  = rgn_vld && (frag_addr == rgn_end);
    end
endmodule

// File: rtl/sg_region_builder.sv
module sg_region_builder
    import sgb_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int FLEN_W = 20,
    parameter int RLEN_W = 24,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frag_valid,
    output logic              frag_ready,
    input  logic [31:0]       frag_addr,
    input  logic [FLEN_W-1:0] frag_len,
    input  logic              frag_last,
    output logic              tbl_we,
    output logic [IDX_W-1:0]  tbl_idx,
    output logic [63:0]       tbl_data,
    output logic              build_done,
    output logic              err_overflow,
    output logic              err_empty,
    output logic [CNT_W-1:0]  entry_count
);
    typedef struct packed {
        bld_st_e             st;
        logic                rgn_vld;
        logic [ADDR_W-1:0]   rgn_base;
        logic [RLEN_W-1:0]   rgn_len;
        logic [ADDR_W-1:0]   cur_addr;
        logic [RLEN_W-1:0]   cur_rem;
        logic                end_seen;
        logic                pend_vld;
        logic [ADDR_W-1:0]   pend_addr;
        logic [CNT_FLD-1:0]  pend_cnt;
        logic [CNT_W-1:0]    n;
        logic                we;
        logic [IDX_W-1:0]    widx;
        logic [WORD_W-1:0]   wdata;
        logic                done;
        logic                err_ovf;
        logic                err_emp;
    } state_t;

    state_t q, d;

    logic              contig;
    logic [SPAN_W-1:0] chunk_len;
    logic              last_chunk;
    logic              accept;
    logic              fresh;
    logic              zero_frag;
    logic [RLEN_W-1:0] frag_len_w;

    sgb_merge #(.RLEN_W(RLEN_W)) u_merge (
        .rgn_vld   (q.rgn_vld),
        .rgn_base  (q.rgn_base),
        .rgn_len   (q.rgn_len),
        .frag_addr (frag_addr),
        .contig    (contig)
    );

    sgb_chunker #(.RLEN_W(RLEN_W)) u_chunk (
        .cur_addr   (q.cur_addr),
        .cur_rem    (q.cur_rem),
        .chunk_len  (chunk_len),
        .last_chunk (last_chunk)
    );

    assign frag_ready = (q.st == ST_ACCEPT) || (q.st == ST_DRAIN);
    assign accept     = frag_valid && frag_ready;
    assign fresh      = q.done || q.err_ovf || q.err_emp;
    assign zero_frag  = (frag_len == '0);
    assign frag_len_w = RLEN_W'(frag_len);

    always_comb begin
        d    = q;
        d.we = 1'b0;
        unique case (q.st)
            ST_ACCEPT: begin
                if (accept) begin
                    if (fresh) begin
                        d.n       = '0;
                        d.done    = 1'b0;
                        d.err_ovf = 1'b0;
                        d.err_emp = 1'b0;
                    end
                    if (!zero_frag) begin
                        if (contig) begin
                            d.rgn_len = q.rgn_len + frag_len_w;
                        end else if (q.rgn_vld) begin
                            d.cur_addr = q.rgn_base;
                            d.cur_rem  = q.rgn_len;
                            d.rgn_base = frag_addr;
                            d.rgn_len  = frag_len_w;
                            d.st       = ST_SPLIT;
                        end else begin
                            d.rgn_vld  = 1'b1;
                            d.rgn_base = frag_addr;
                            d.rgn_len  = frag_len_w;
                        end
                    end
                    if (frag_last) begin
                        d.end_seen = 1'b1;
                        if (d.st != ST_SPLIT) begin
                            if (d.rgn_vld) begin
                                d.cur_addr = d.rgn_base;
                                d.cur_rem  = d.rgn_len;
                                d.rgn_vld  = 1'b0;
                                d.st       = ST_SPLIT;
                            end else begin
                                d.err_emp  = 1'b1;
                                d.n        = '0;
                                d.end_seen = 1'b0;
                            end
                        end
                    end
                end
            end
            ST_SPLIT: begin
                if (q.n == CNT_W'(DEPTH)) begin
                    d.rgn_vld  = 1'b0;
                    d.pend_vld = 1'b0;
                    d.end_seen = 1'b0;
                    if (q.end_seen) begin
                        d.err_ovf = 1'b1;
                        d.st      = ST_ACCEPT;
                    end else begin
                        d.st = ST_DRAIN;
                    end
                end else begin
                    if (q.pend_vld) begin
                        d.we    = 1'b1;
                        d.widx  = IDX_W'(q.n - CNT_W'(1));
                        d.wdata = pack_desc(q.pend_addr, q.pend_cnt, 1'b0);
                    end
                    d.pend_vld  = 1'b1;
                    d.pend_addr = q.cur_addr;
                    d.pend_cnt  = chunk_len[CNT_FLD-1:0];
                    d.n         = q.n + CNT_W'(1);
                    d.cur_addr  = q.cur_addr + ADDR_W'(chunk_len);
                    d.cur_rem   = q.cur_rem - RLEN_W'(chunk_len);
                    if (last_chunk) begin
                        if (q.end_seen && q.rgn_vld) begin
                            d.cur_addr = q.rgn_base;
                            d.cur_rem  = q.rgn_len;
                            d.rgn_vld  = 1'b0;
                        end else if (q.end_seen) begin
                            d.st = ST_FLUSH;
                        end else begin
                            d.st = ST_ACCEPT;
                        end
                    end
                end
            end
            ST_FLUSH: begin
                d.we       = 1'b1;
                d.widx     = IDX_W'(q.n - CNT_W'(1));
                d.wdata    = pack_desc(q.pend_addr, q.pend_cnt, 1'b1);
                d.pend_vld = 1'b0;
                d.end_seen = 1'b0;
                d.done     = 1'b1;
                d.st       = ST_ACCEPT;
            end
            ST_DRAIN: begin
                if (accept && frag_last) begin
                    d.err_ovf = 1'b1;
                    d.st      = ST_ACCEPT;
                end
            end
            default: d.st = ST_ACCEPT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_ACCEPT, default: '0};
        end else begin
            q <= d;
        end
    end

    assign tbl_we       = q.we;
    assign tbl_idx      = q.widx;
    assign tbl_data     = q.wdata;
    assign build_done   = q.done;
    assign err_overflow = q.err_ovf;
    assign err_empty    = q.err_emp;
    assign entry_count  = q.n;
endmodule

// File: rtl/sgb_checker.sv
module sgb_checker #(
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tbl_we,
    input logic [IDX_W-1:0] tbl_idx,
    input logic [63:0]      tbl_data,
    input logic             build_done,
    input logic             err_overflow,
    input logic             err_empty,
    input logic [CNT_W-1:0] entry_count
);
    logic [31:0] span_end;
    always_comb begin
        span_end = {16'b0, tbl_data[15:0]} +
                   ((tbl_data[47:32] == 16'h0) ? 32'h10000 : {16'b0, tbl_data[47:32]});
    end

    // R1
    fmt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |-> (tbl_data[62:48] == 15'h0));

    // R3
    no_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |-> (span_end <= 32'h10000));

    // R5
    eot_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_we && tbl_data[63]) |-> build_done);

    // R6
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |-> (CNT_W'(tbl_idx) < entry_count));

    // R7
    excl_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(build_done && (err_overflow || err_empty)));

    // R8
    empty_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_empty |-> (entry_count == '0 && !tbl_we));
endmodule

bind sg_region_builder sgb_checker #(.DEPTH(DEPTH)) u_sgb_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tbl_we       (tbl_we),
    .tbl_idx      (tbl_idx),
    .tbl_data     (tbl_data),
    .build_done   (build_done),
    .err_overflow (err_overflow),
    .err_empty    (err_empty),
    .entry_count  (entry_count)
);

// File: tb/test_sg_region_builder.sv
module test_sg_region_builder;
    localparam int DEPTH  = 256;
    localparam int FLEN_W = 20;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int MAXF   = 300;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frag_valid = 1'b0;
    logic              frag_ready;
    logic [31:0]       frag_addr = '0;
    logic [FLEN_W-1:0] frag_len = '0;
    logic              frag_last = 1'b0;
    logic              tbl_we;
    logic [IDX_W-1:0]  tbl_idx;
    logic [63:0]       tbl_data;
    logic              build_done, err_overflow, err_empty;
    logic [CNT_W-1:0]  entry_count;

    sg_region_builder #(.DEPTH(DEPTH), .FLEN_W(FLEN_W)) i_sg_region_builder (
        .clk(clk), .rst_n(rst_n), .frag_valid(frag_valid), .frag_ready(frag_ready),
        .frag_addr(frag_addr), .frag_len(frag_len), .frag_last(frag_last),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_data(tbl_data),
        .build_done(build_done), .err_overflow(err_overflow), .err_empty(err_empty),
        .entry_count(entry_count)
    );

    always #10 clk = ~clk;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int wr_cnt = 0;
    logic [63:0] mem [DEPTH];
    logic [31:0] f_addr [MAXF];
    int          f_len  [MAXF];
    int          nf;
    logic [63:0] exp_w [DEPTH];
    int          exp_n;
    bit          exp_ovf;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (tbl_we) begin
            mem[tbl_idx] <= tbl_data;
            wr_cnt <= wr_cnt + 1;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic model();
        logic [31:0] rb, a;
        longint rl, c, room;
        bit rv;
        exp_n = 0;
        exp_ovf = 0;
        rv = 0;
        rb = 0;
        rl = 0;
        for (int i = 0; i <= nf; i++) begin
            bit close_now;
            close_now = (i == nf);
            if (!close_now && f_len[i] != 0 && rv && f_addr[i] == rb + 32'(rl)) begin
                rl += f_len[i];
            end else if (close_now || f_len[i] != 0) begin
                if (rv) begin
                    a = rb;
                    while (rl > 0 && !exp_ovf) begin
                        room = 65536 - longint'(a[15:0]);
                        c = (rl < room) ? rl : room;
                        if (exp_n == DEPTH) begin
                            exp_ovf = 1;
                        end else begin
                            exp_w[exp_n] = {1'b0, 15'b0, 16'(c), a};
                            exp_n++;
                            a = a + 32'(c);
                            rl -= c;
                        end
                    end
                end
                if (!close_now) begin
                    rb = f_addr[i];
                    rl = f_len[i];
                    rv = 1;
                end
            end
        end
        if (exp_n > 0 && !exp_ovf) exp_w[exp_n-1][63] = 1'b1;
    endtask

    task automatic send(input logic [31:0] a, input int l, input bit last);
        @(negedge clk);
        frag_valid = 1'b1;
        frag_addr  = a;
        frag_len   = FLEN_W'(l);
        frag_last  = last;
        while (!frag_ready) @(negedge clk);
        @(posedge clk);
        #1;
        frag_valid = 1'b0;
    endtask

    task automatic run_build(input string req);
        int wr0;
        model();
        for (int i = 0; i < DEPTH; i++) mem[i] = 64'hA5A5_A5A5_A5A5_A5A5;
        @(negedge clk);
        wr0 = wr_cnt;
        for (int i = 0; i < nf; i++) send(f_addr[i], f_len[i], i == nf - 1);
        @(negedge clk);
        while (!(build_done || err_overflow || err_empty)) @(negedge clk);
        @(negedge clk);
        if (exp_ovf) begin
            check(err_overflow && !build_done, {req, " R7 overflow"}, err_overflow, 1);
        end else if (exp_n == 0) begin
            check(err_empty && !build_done, {req, " R8 empty flag"}, err_empty, 1);
            check(entry_count == 0 && wr_cnt == wr0, {req, " R8 no write"}, wr_cnt - wr0, 0);
        end else begin
            check(build_done && entry_count == CNT_W'(exp_n), {req, " R6 count"}, entry_count, exp_n);
            check(wr_cnt - wr0 == exp_n, {req, " R6 writes"}, wr_cnt - wr0, exp_n);
            for (int i = 0; i < exp_n; i++)
                check(mem[i] == exp_w[i], {req, " R1 R3 R4 R5 entry"}, mem[i], exp_w[i]);
        end
    endtask

    initial begin
        logic [31:0] prev_end;
        @(negedge clk);
        @(negedge clk);
        check(frag_ready && !build_done && !err_overflow && !err_empty && !tbl_we,
              "R10 reset state", {frag_ready, build_done, err_overflow, err_empty}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);

        // single small fragment
        nf = 1; f_addr[0] = 32'h0010_0000; f_len[0] = 512;
        run_build("R1");
        // crossing one 64 KB boundary
        nf = 1; f_addr[0] = 32'h0002_FF00; f_len[0] = 1024;
        run_build("R3");
        // full aligned 64 KB chunks: counts of 0
        nf = 1; f_addr[0] = 32'h0004_0000; f_len[0] = 32'h30000;
        send(f_addr[0], f_len[0], 1'b1);
        @(negedge clk);
        check(!frag_ready, "R10 ready low while splitting", frag_ready, 0);
        while (!build_done) @(negedge clk);
        @(negedge clk);
        check(mem[0] == {1'b0, 15'b0, 16'h0, 32'h0004_0000} && mem[2][63],
              "R4 full chunk count", mem[0], {16'h0, 16'h0, 32'h0004_0000});
        // contiguous merge across fragments
        nf = 3; f_addr[0] = 32'h1000; f_len[0] = 256;
        f_addr[1] = 32'h1100; f_len[1] = 256; f_addr[2] = 32'h1200; f_len[2] = 512;
        run_build("R2 merge");
        // non-contiguous
        nf = 3; f_addr[0] = 32'h1000; f_len[0] = 256;
        f_addr[1] = 32'h8000; f_len[1] = 256; f_addr[2] = 32'h1100; f_len[2] = 64;
        run_build("R2 split");
        // zero-length in middle keeps merge
        nf = 3; f_addr[0] = 32'h2000; f_len[0] = 128;
        f_addr[1] = 32'h9999_0000; f_len[1] = 0; f_addr[2] = 32'h2080; f_len[2] = 128;
        run_build("R9");
        check(entry_count == 1, "R9 single entry", entry_count, 1);
        // empty list
        nf = 2; f_addr[0] = 32'h0; f_len[0] = 0; f_addr[1] = 32'h40; f_len[1] = 0;
        run_build("R8");
        // exactly DEPTH descriptors
        nf = DEPTH;
        for (int i = 0; i < nf; i++) begin f_addr[i] = 32'(i * 64); f_len[i] = 2; end
        run_build("R6 full table");
        // overflow on the final fragment
        nf = DEPTH + 1;
        for (int i = 0; i < nf; i++) begin f_addr[i] = 32'(i * 64); f_len[i] = 2; end
        run_build("R7 at end");
        // overflow mid-list, drain, then a fresh build
        nf = DEPTH + 20;
        for (int i = 0; i < nf; i++) begin f_addr[i] = 32'(i * 64); f_len[i] = 2; end
        run_build("R7 drain");
        nf = 1; f_addr[0] = 32'h5000; f_len[0] = 16;
        run_build("R10 after error");

        // random builds
        void'($urandom(32'h5EED_1234));
        for (int b = 0; b < 40; b++) begin
            nf = 1 + int'($urandom_range(0, 11));
            prev_end = 32'h0;
            for (int i = 0; i < nf; i++) begin
                int sel;
                sel = int'($urandom_range(0, 9));
                if (i > 0 && sel < 5) f_addr[i] = prev_end;
                else if (sel < 7) f_addr[i] = {4'h1, 12'($urandom), 8'hFF, 7'($urandom), 1'b0};
                else f_addr[i] = {4'h2, 27'($urandom), 1'b0};
                f_len[i] = ($urandom_range(0, 9) == 0) ? 0 : int'($urandom_range(1, 32'h17FFF)) * 2;
                prev_end = f_addr[i] + 32'(f_len[i]);
            end
            run_build("R2 R3 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule